// File: doc/BRIEF.md
# Saturating DC Offset Remover

This block strips the DC component from a stream of 16-bit signed receive samples. It keeps a running average of the input in a leaky integrator and subtracts that average from every accepted sample. The difference is clipped to the 16-bit signed limits rather than wrapped in two's complement. An input near full scale therefore cannot flip sign when the offset estimate is nonzero, and the scaling stage upstream can use one extra bit of headroom.

The sample input may be wider than 16 bits, for example when it carries a repeated sign bit from upstream packing. Only the low 16 bits are used. A tracking enable decides whether accepted samples move the estimate. When tracking is off, the estimate is frozen but is still subtracted.

Each cycle the top module decodes one of three actions:
- PATH_IDLE: no valid sample is present, and nothing changes.
- PATH_TRACK: a sample is valid and tracking is on. The output is produced and the integrator is updated.
- PATH_HOLD: a sample is valid and tracking is off. The output is produced and the integrator keeps its value.

The transitions between these actions follow only `in_valid` and `track_en` in the same cycle. No action depends on earlier cycles.

Top module: `dcr_offset_remover`

## Requirements
- R1: Only bits [15:0] of `in_data` are used, read as a two's complement sample. Bits above bit 15 have no effect on the output or on the estimate.
- R2: `out_valid` equals the `in_valid` of the previous clock cycle.
- R3: The offset estimate is `acc >>> 14`. For each accepted sample x, `out_data` is x minus the estimate as it stood before that sample.
- R4: When a sample is accepted with `track_en` high, the integrator is updated as acc = acc + x - (acc >>> 14). When `track_en` is low, acc holds its value and the frozen estimate is still subtracted.
- R5: A difference above +32767 produces `out_data` = 32767 (16'h7FFF) with `out_clip` = 1. A positive sample minus a negative estimate never yields a negative output.
- R6: A difference below -32768 produces `out_data` = -32768 (16'h8000) with `out_clip` = 1. A negative sample minus a positive estimate never yields a non-negative output.
- R7: `out_clip` is 0 for every in-range difference.
- R8: Synchronous reset (`rst` high) clears the integrator to zero and drives `out_valid` = 0, `out_data` = 0 and `out_clip` = 0.
- R9: A cycle with `in_valid` low leaves the integrator, `out_data` and `out_clip` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | IN_W (18) | Raw input sample; only the low 16 bits are used |
| track_en | input | 1 | 1: accepted samples update the estimate; 0: the estimate is frozen |
| out_valid | output | 1 | Output strobe, one cycle after `in_valid` |
| out_data | output | 16 | Sample with the offset removed and clipped, signed |
| out_clip | output | 1 | The current output was clipped |

## Verification
On every cycle the assertions check four things:
- the one-cycle lag of `out_valid`;
- that a clipped output sits on a rail;
- that a sample and an estimate of opposite sign never produce a wrapped result of the wrong sign;
- that the estimate and the output registers stay still when no sample is tracked or accepted.

Other behaviour only the bench's scenarios can show. This covers the numeric result of the leaky integrator as it converges over tens of thousands of samples toward a large positive or negative DC level. It also covers the exact output while the estimate is frozen, the removal of the upper input bits, and the clearing of the estimate by a reset in mid-run.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

    localparam int SAMPLE_W = 16;

    typedef enum logic [1:0] {
        CLIP_NONE = 2'd0,
        CLIP_HIGH = 2'd1,
        CLIP_LOW  = 2'd2
    } clip_e;

    typedef enum logic [1:0] {
        PATH_IDLE  = 2'd0,
        PATH_TRACK = 2'd1,
        PATH_HOLD  = 2'd2
    } path_e;

endpackage

// File: rtl/dcr_input_trim.sv
module dcr_input_trim #(
    parameter int IN_W  = 18,
    parameter int OUT_W = 16
) (
    input  logic [IN_W-1:0]         raw,
    output logic signed [OUT_W-1:0] sample
);
    // Upper bits (packing, repeated sign) are discarded
    generate
        if (IN_W > OUT_W) begin : g_drop
            logic [IN_W-OUT_W-1:0] unused_hi;
            assign unused_hi = raw[IN_W-1:OUT_W];
            assign sample    = $signed(raw[OUT_W-1:0]);
        end else if (IN_W == OUT_W) begin : g_same
            assign sample = $signed(raw);
        end else begin : g_extend
            assign sample = $signed({{(OUT_W-IN_W){raw[IN_W-1]}}, raw});
        end
    endgenerate
endmodule

// File: rtl/dcr_leaky_avg.sv
module dcr_leaky_avg #(
    parameter int DATA_W  = 16,
    parameter int SHIFT_K = 14
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     upd,
    input  logic signed [DATA_W-1:0] x,
    output logic signed [DATA_W-1:0] est
);
    // One guard bit above the steady-state range of x * 2^K
    localparam int ACC_W = DATA_W + SHIFT_K + 1;

    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] acc_d;
    logic signed [ACC_W-1:0] x_ext;
    logic signed [ACC_W-1:0] est_ext;
    logic [ACC_W-DATA_W-1:0] unused_est_hi;

    always_comb begin
        x_ext   = {{(ACC_W-DATA_W){x[DATA_W-1]}}, x};
        est_ext = acc_q >>> SHIFT_K;
        acc_d   = acc_q + x_ext - est_ext;
    end

    assign est           = est_ext[DATA_W-1:0];
    assign unused_est_hi = est_ext[ACC_W-1:DATA_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (upd) begin
            acc_q <= acc_d;
        end
    end
endmodule

// File: rtl/dcr_sat_sub.sv
module dcr_sat_sub
    import dcr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic signed [DATA_W-1:0] a,
    input  logic signed [DATA_W-1:0] b,
    output logic signed [DATA_W-1:0] y,
    output clip_e                    kind
);
    localparam logic signed [DATA_W-1:0] MAX_V = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic signed [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};

    logic signed [DATA_W:0] diff;

    always_comb begin
        diff = {a[DATA_W-1], a} - {b[DATA_W-1], b};
        // Top two bits disagree: the result left the DATA_W range
        if (diff[DATA_W] != diff[DATA_W-1]) begin
            kind = diff[DATA_W] ? CLIP_LOW : CLIP_HIGH;
        end else begin
            kind = CLIP_NONE;
        end
        unique case (kind)
            CLIP_HIGH: y = MAX_V;
            CLIP_LOW:  y = MIN_V;
            default:   y = diff[DATA_W-1:0];
        endcase
    end
endmodule

// File: rtl/dcr_offset_remover.sv
module dcr_offset_remover
    import dcr_pkg::*;
#(
    parameter int IN_W    = 18,
    parameter int DATA_W  = SAMPLE_W,
    parameter int SHIFT_K = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [IN_W-1:0]   in_data,
    input  logic              track_en,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_clip
);
    logic signed [DATA_W-1:0] x_trim;
    logic signed [DATA_W-1:0] offset_est;
    logic signed [DATA_W-1:0] sub_y;
    clip_e                    sub_kind;
    path_e                    path;
    logic                     acc_upd;

    dcr_input_trim #(.IN_W(IN_W), .OUT_W(DATA_W)) u_trim (
        .raw    (in_data),
        .sample (x_trim)
    );

    // Per-cycle action decode
    always_comb begin
        if (!in_valid)     path = PATH_IDLE;
        else if (track_en) path = PATH_TRACK;
        else               path = PATH_HOLD;
    end

    always_comb begin
        unique case (path)
            PATH_TRACK: acc_upd = 1'b1;
            PATH_HOLD:  acc_upd = 1'b0;
            default:    acc_upd = 1'b0;
        endcase
    end

    dcr_leaky_avg #(.DATA_W(DATA_W), .SHIFT_K(SHIFT_K)) u_avg (
        .clk (clk),
        .rst (rst),
        .upd (acc_upd),
        .x   (x_trim),
        .est (offset_est)
    );

    dcr_sat_sub #(.DATA_W(DATA_W)) u_sub (
        .a    (x_trim),
        .b    (offset_est),
        .y    (sub_y),
        .kind (sub_kind)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_clip  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            unique case (path)
                PATH_TRACK, PATH_HOLD: begin
                    out_data <= sub_y;
                    out_clip <= (sub_kind != CLIP_NONE);
                end
                default: begin
                    out_data <= out_data;
                    out_clip <= out_clip;
                end
            endcase
        end
    end
endmodule

// File: rtl/dcr_offset_remover_chk.sv
module dcr_offset_remover_chk #(
    parameter int DATA_W = 16
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     in_valid,
    input logic                     track_en,
    input logic                     out_valid,
    input logic [DATA_W-1:0]        out_data,
    input logic                     out_clip,
    input logic signed [DATA_W-1:0] x_trim,
    input logic signed [DATA_W-1:0] offset_est
);
    localparam logic [DATA_W-1:0] HI_RAIL = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] LO_RAIL = {1'b1, {(DATA_W-1){1'b0}}};

    AST_VALID_LAG: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (out_valid == $past(in_valid))); // R2

    AST_CLIP_ON_RAIL: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_clip) |-> (out_data == HI_RAIL || out_data == LO_RAIL)); // R5

    AST_NO_WRAP_HIGH: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(in_valid) && $past(x_trim) > 0 && $past(offset_est) < 0)
        |-> !out_data[DATA_W-1]); // R5

    AST_NO_WRAP_LOW: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(in_valid) && $past(x_trim) < 0 && $past(offset_est) > 0)
        |-> out_data[DATA_W-1]); // R6

    AST_EST_FROZEN: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !$past(in_valid && track_en)) |-> $stable(offset_est)); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !$past(in_valid)) |-> ($stable(out_data) && $stable(out_clip))); // R9
endmodule

bind dcr_offset_remover dcr_offset_remover_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .track_en   (track_en),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_clip   (out_clip),
    .x_trim     (x_trim),
    .offset_est (offset_est)
);

// File: tb/dcr_offset_remover_tb.sv
`timescale 1ns/1ps
module dcr_offset_remover_tb;
    localparam int IN_W = 18;
    localparam int DW   = 16;
    localparam int K    = 14;
    localparam int NVEC = 8;
    localparam int WATCHDOG = 190000;

    // {raw input, expected output}; estimate is zero and frozen
    localparam logic [IN_W+DW-1:0] VEC [NVEC] = '{
        {18'h00005, 16'h0005},
        {18'h3FFFF, 16'hFFFF},
        {18'h37FFF, 16'h7FFF},
        {18'h08000, 16'h8000},
        {18'h10123, 16'h0123},
        {18'h2ABCD, 16'hABCD},
        {18'h00000, 16'h0000},
        {18'h1C000, 16'hC000}
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic [IN_W-1:0] in_data = '0;
    logic            track_en = 1'b0;
    logic            out_valid;
    logic [DW-1:0]   out_data;
    logic            out_clip;

    int     n_checks = 0;
    int     n_fail   = 0;
    int     cycles   = 0;
    longint m_acc    = 0;
    longint m_out    = 0;
    bit     m_clip   = 1'b0;

    always #4 clk = ~clk;

    dcr_offset_remover #(.IN_W(IN_W), .DATA_W(DW), .SHIFT_K(K)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .track_en  (track_en),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_clip  (out_clip)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // One clock with one input; model from R3/R4/R5/R6/R9
    task automatic step(input logic [IN_W-1:0] raw, input bit v, input bit en, input string req);
        longint x;
        longint off;
        longint d;
        @(negedge clk);
        in_data  = raw;
        in_valid = v;
        track_en = en;
        x   = longint'($signed(raw[DW-1:0]));
        off = m_acc >>> K;
        if (v) begin
            d = x - off;
            m_clip = 1'b0;
            if (d > 32767)  begin d = 32767;  m_clip = 1'b1; end
            if (d < -32768) begin d = -32768; m_clip = 1'b1; end
            m_out = d;
            if (en) m_acc = m_acc + x - off;
        end
        @(posedge clk);
        #1;
        check(out_valid == v, "R2 out_valid", longint'(out_valid), longint'(v));
        check(longint'($signed(out_data)) == m_out, req, longint'($signed(out_data)), m_out);
        check(out_clip == m_clip, {req, " clip"}, longint'(out_clip), longint'(m_clip));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_acc = 0;
        m_out = 0;
        m_clip = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                check(1'b0, "watchdog", cycles, WATCHDOG);
                finish_run();
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        check(out_valid == 1'b0, "R8 reset valid", longint'(out_valid), 0);
        check(out_data == '0, "R8 reset data", longint'(out_data), 0);
        check(out_clip == 1'b0, "R8 reset clip", longint'(out_clip), 0);
        rst = 1'b0;

        // R1: table walk with estimate zero and frozen
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][IN_W+DW-1:DW], 1'b1, 1'b0, "R1 trim");
            check(out_data == VEC[i][DW-1:0], "R1 table",
                  longint'(out_data), longint'(VEC[i][DW-1:0]));
        end

        // R9: idle cycles with garbage data hold the output
        step(18'h12345, 1'b1, 1'b1, "R3 first track");
        step(18'h2FFFF, 1'b0, 1'b1, "R9 idle");
        step(18'h00777, 1'b0, 1'b0, "R9 idle");

        // R3/R4: converge toward -20000
        for (int i = 0; i < 50000; i++) step(18'h3B1E0, 1'b1, 1'b1, "R3 track neg");
        check((m_acc >>> K) < -18000, "R3 converge neg", m_acc >>> K, -18000);
        // R5: clip high while frozen
        step(18'h07FFF, 1'b1, 1'b0, "R5 clip high");
        check(out_data == 16'h7FFF && out_clip, "R5 rail", longint'(out_data), 32767);
        step(18'h00100, 1'b1, 1'b0, "R4 frozen");
        step(18'h00100, 1'b1, 1'b0, "R4 frozen repeat");
        step(18'h3C000, 1'b1, 1'b0, "R7 in range");
        check(out_clip == 1'b0, "R7 no clip", longint'(out_clip), 0);

        // converge toward +20000, then R6
        for (int i = 0; i < 50000; i++) step(18'h04E20, 1'b1, 1'b1, "R3 track pos");
        check((m_acc >>> K) > 17000, "R3 converge pos", m_acc >>> K, 17000);
        step(18'h08000, 1'b1, 1'b0, "R6 clip low");
        check(out_data == 16'h8000 && out_clip, "R6 rail", longint'(out_data), -32768);
        step(18'h38000, 1'b1, 1'b1, "R6 clip low track");

        // R8: reset mid-run clears the estimate
        do_reset();
        check(out_valid == 1'b0 && out_data == '0, "R8 mid reset", longint'(out_data), 0);
        step(18'h00064, 1'b1, 1'b0, "R8 estimate cleared");
        check(out_data == 16'd100, "R8 passthrough", longint'(out_data), 100);

        finish_run();
    end
endmodule